// File: doc/BRIEF.md
# Side-Peak Lock Detector and Code-Phase Jump Controller

This block watches a BOC(1,1) code-tracking loop for lock on one of the two false correlation peaks. Those peaks lie roughly half a chip either side of the true peak. At those points the ordinary early-minus-late error is zero, so the loop cannot tell it is wrong. Two additional correlators sit half a subcarrier period before and after the prompt replica. At every integration dump the block subtracts the late one from the early one. A large difference means the loop sits on a shoulder rather than the centre peak.

When the magnitude of that difference is above a programmable threshold and the receiver is tracking, the block sends the code generator a one-cycle jump command. The command carries a direction and a fixed step of half a subcarrier period, expressed in code-phase units. A positive difference means the early side is stronger, so the code phase is advanced. A negative difference retards it. After a jump, a programmable number of dumps is ignored so that the correlators can settle on the new alignment.

Top module: `boc_side_peak_jumper`

## Requirements
- R1: The signed difference d = ve_i - vl_i is formed at full precision. A jump is raised only when |d| is strictly greater than the unsigned thresh_i. A magnitude equal to the threshold raises no jump.
- R2: When a jump is raised, jump_adv_o is 1 (advance the code phase) if d is positive, and 0 (retard) if d is negative.
- R3: jump_o is high for exactly the one clock cycle that follows a cycle with dump_i high, and is never high in any other cycle.
- R4: While jump_o is high, jump_step_o equals 2^CHIP_FRAC_W / (2*SC_RATIO), which is half a subcarrier period (512 with the default parameters). While jump_o is low, jump_step_o and jump_adv_o are 0.
- R5: A dump that arrives with track_en_i low raises no jump, whatever the correlator values.
- R6: A jump loads the holdoff count from holdoff_i. Each later dump with a nonzero count raises no jump and lowers the count by one, whether tracking is on or off. A holdoff of 0 blocks nothing.
- R7: While rst_ni is low, and after it is released, all outputs are 0 and the holdoff count is cleared. A dump after reset can therefore jump at once.
- R8: Full-scale inputs do not overflow. ve_i = +32767 with vl_i = -32768 gives |d| = 65535, which exceeds a threshold of 65534 but not a threshold of 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dump_i | input | 1 | Integration-period strobe; correlator inputs are valid this cycle |
| track_en_i | input | 1 | Receiver is in the tracking state |
| ve_i | input | MAG_W (16) | Very-early correlator magnitude, signed |
| vl_i | input | MAG_W (16) | Very-late correlator magnitude, signed |
| thresh_i | input | MAG_W+1 (17) | Jump threshold on \|ve-vl\|, unsigned |
| holdoff_i | input | HOLD_W (8) | Dumps to block after a jump |
| jump_o | output | 1 | One-cycle jump command |
| jump_adv_o | output | 1 | 1 = advance code phase, 0 = retard |
| jump_step_o | output | CHIP_FRAC_W (10) | Jump size in code-phase units |

## Verification
Two functions can land on the same dump: the holdoff window expiring, and a threshold crossing. The bench sets up a jump with a holdoff of two and then presents large differences on the next three dumps. It expects the first two to be suppressed and the third to jump. It also places a dump with tracking off inside a holdoff window. That dump must still consume one count, so the next tracked dump jumps. Every dump result is predicted by an independent model of the count and compared in the cycle after the strobe.

// File: rtl/bsj_pkg.sv
package bsj_pkg;
  typedef enum logic {
    DIR_RETARD  = 1'b0,
    DIR_ADVANCE = 1'b1
  } jump_dir_e;

  typedef struct packed {
    logic      hit;
    jump_dir_e dir;
  } verdict_t;
endpackage

// File: rtl/bsj_discrim.sv
module bsj_discrim
  import bsj_pkg::*;
#(
  parameter int unsigned MAG_W = 16,
  localparam int unsigned THR_W = MAG_W + 1
) (
  input  logic signed [MAG_W-1:0] ve_i,
  input  logic signed [MAG_W-1:0] vl_i,
  input  logic        [THR_W-1:0] thresh_i,
  output verdict_t                verdict_o
);
  logic signed [THR_W-1:0] diff;
  logic        [THR_W-1:0] mag;

  // one guard bit: full-scale difference never wraps
  always_comb begin
    diff = THR_W'(ve_i) - THR_W'(vl_i);
    mag  = diff[THR_W-1] ? $unsigned(-diff) : $unsigned(diff);
    verdict_o.hit = (mag > thresh_i);
    verdict_o.dir = diff[THR_W-1] ? DIR_RETARD : DIR_ADVANCE;
  end
endmodule

// File: rtl/bsj_holdoff.sv
module bsj_holdoff #(
  parameter int unsigned HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dump_i,
  input  logic              fire_i,
  input  logic [HOLD_W-1:0] load_i,
  output logic              open_o
);
  logic [HOLD_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (dump_i) begin
      if (fire_i)          cnt_q <= load_i;
      else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o = (cnt_q == '0);
endmodule

// File: rtl/boc_side_peak_jumper.sv
module boc_side_peak_jumper
  import bsj_pkg::*;
#(
  parameter int unsigned MAG_W       = 16,
  parameter int unsigned HOLD_W      = 8,
  parameter int unsigned CHIP_FRAC_W = 10,
  parameter int unsigned SC_RATIO    = 1,
  localparam int unsigned THR_W      = MAG_W + 1,
  localparam int unsigned STEP_VAL   = (1 << CHIP_FRAC_W) / (2 * SC_RATIO)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    dump_i,
  input  logic                    track_en_i,
  input  logic signed [MAG_W-1:0] ve_i,
  input  logic signed [MAG_W-1:0] vl_i,
  input  logic        [THR_W-1:0] thresh_i,
  input  logic       [HOLD_W-1:0] holdoff_i,
  output logic                    jump_o,
  output logic                    jump_adv_o,
  output logic [CHIP_FRAC_W-1:0]  jump_step_o
);
  verdict_t verdict;
  logic     hold_open;
  logic     fire;
  logic     jump_q;
  logic     adv_q;

  bsj_discrim #(.MAG_W(MAG_W)) i_discrim (
    .ve_i      (ve_i),
    .vl_i      (vl_i),
    .thresh_i  (thresh_i),
    .verdict_o (verdict)
  );

  assign fire = dump_i & track_en_i & verdict.hit & hold_open;

  bsj_holdoff #(.HOLD_W(HOLD_W)) i_holdoff (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dump_i (dump_i),
    .fire_i (fire),
    .load_i (holdoff_i),
    .open_o (hold_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      jump_q <= 1'b0;
      adv_q  <= 1'b0;
    end else begin
      jump_q <= fire;
      adv_q  <= fire & (verdict.dir == DIR_ADVANCE);
    end
  end

  assign jump_o      = jump_q;
  assign jump_adv_o  = adv_q;
  assign jump_step_o = jump_q ? CHIP_FRAC_W'(STEP_VAL) : '0;
endmodule

// File: rtl/bsj_checker.sv
module bsj_checker #(
  parameter int unsigned MAG_W       = 16,
  parameter int unsigned CHIP_FRAC_W = 10,
  parameter int unsigned SC_RATIO    = 1,
  localparam int unsigned THR_W      = MAG_W + 1,
  localparam int unsigned STEP_VAL   = (1 << CHIP_FRAC_W) / (2 * SC_RATIO)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    dump_i,
  input logic                    track_en_i,
  input logic signed [MAG_W-1:0] ve_i,
  input logic signed [MAG_W-1:0] vl_i,
  input logic        [THR_W-1:0] thresh_i,
  input logic                    jump_o,
  input logic                    jump_adv_o,
  input logic [CHIP_FRAC_W-1:0]  jump_step_o
);
  logic       ve_gt_vl;
  logic [31:0] abs_d;
  always_comb begin
    ve_gt_vl = (ve_i > vl_i);
    abs_d    = ve_gt_vl ? 32'(int'(ve_i) - int'(vl_i)) : 32'(int'(vl_i) - int'(ve_i));
  end

  assert_after_dump_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> $past(dump_i));
  assert_no_repeat_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_o && !$past(dump_i, 1)) |-> 1'b0 || !jump_o);
  assert_above_thresh_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> ($past(abs_d) > 32'($past(thresh_i))));
  assert_dir_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (jump_adv_o == $past(ve_gt_vl)));
  assert_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> (jump_step_o == CHIP_FRAC_W'(STEP_VAL)));
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_o |-> (jump_step_o == '0 && !jump_adv_o));
  assert_tracking_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_o |-> $past(track_en_i));
endmodule

bind boc_side_peak_jumper bsj_checker #(
  .MAG_W(MAG_W), .CHIP_FRAC_W(CHIP_FRAC_W), .SC_RATIO(SC_RATIO)
) i_bsj_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .dump_i(dump_i), .track_en_i(track_en_i),
  .ve_i(ve_i), .vl_i(vl_i), .thresh_i(thresh_i), .jump_o(jump_o),
  .jump_adv_o(jump_adv_o), .jump_step_o(jump_step_o)
);

// File: tb/test_boc_side_peak_jumper.sv
`timescale 1ns/1ps
module test_boc_side_peak_jumper;
  localparam int MAG_W = 16;
  localparam int HOLD_W = 8;
  localparam int CFW = 10;
  localparam int STEP = 512;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dump = 1'b0;
  logic track = 1'b0;
  logic signed [MAG_W-1:0] ve = '0;
  logic signed [MAG_W-1:0] vl = '0;
  logic [MAG_W:0] thr = '0;
  logic [HOLD_W-1:0] hold = '0;
  logic jump, adv;
  logic [CFW-1:0] step;

  int checks = 0;
  int errors = 0;
  int hc = 0;
  bit done = 0;

  typedef struct { bit j; bit a; string tag; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  boc_side_peak_jumper i_boc_side_peak_jumper (
    .clk_i(clk), .rst_ni(rst_n), .dump_i(dump), .track_en_i(track),
    .ve_i(ve), .vl_i(vl), .thresh_i(thr), .holdoff_i(hold),
    .jump_o(jump), .jump_adv_o(adv), .jump_step_o(step)
  );

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic do_dump(int v_e, int v_l, string tag);
    int d, m;
    bit hit;
    @(negedge clk);
    ve = MAG_W'(v_e);
    vl = MAG_W'(v_l);
    dump = 1'b1;
    d = v_e - v_l;
    m = (d < 0) ? -d : d;
    hit = track && (hc == 0) && (m > int'(thr));
    if (hit) hc = int'(hold);
    else if (hc > 0) hc--;
    sb.push_back('{hit, hit && (d > 0), tag});
    @(negedge clk);
    dump = 1'b0;
  endtask

  // monitor
  always begin
    bit d;
    exp_t e;
    @(posedge clk);
    d = dump && rst_n;
    #2;
    if (rst_n && !done) begin
      if (d && sb.size() > 0) begin
        e = sb.pop_front();
        chk(jump == e.j, e.tag, "jump", int'(jump), int'(e.j));
        chk(adv == e.a, e.tag, "dir", int'(adv), int'(e.a));
        chk(step == (e.j ? CFW'(STEP) : '0), e.tag, "step", int'(step), e.j ? STEP : 0);
      end else begin
        chk(jump == 1'b0, "R3", "idle jump", int'(jump), 0);
      end
    end
  end

  initial begin
    #(8 * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(jump == 0 && adv == 0 && step == 0, "R7", "outputs in reset", int'(jump), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(jump == 0 && step == 0, "R7", "outputs after reset", int'(jump), 0);

    thr = 17'd100; hold = 0; track = 1'b1;
    do_dump(500, 100, "R2");
    do_dump(100, 500, "R2");
    do_dump(300, 200, "R1");
    do_dump(301, 200, "R1");
    do_dump(-50, 60, "R2");
    do_dump(-200, -150, "R1");
    // idle cycles with large difference, no strobe
    ve = 16'sd5000; vl = -16'sd5000;
    repeat (4) @(negedge clk);

    track = 1'b0;
    do_dump(1000, 0, "R5");
    do_dump(0, 1000, "R5");
    track = 1'b1;

    // holdoff expiry coinciding with a threshold crossing
    hold = 8'd2;
    do_dump(900, 0, "R6");
    do_dump(900, 0, "R6");
    do_dump(0, 900, "R6");
    hold = 8'd0;
    do_dump(0, 900, "R6");
    do_dump(900, 0, "R6");

    // dump with tracking off still consumes holdoff
    hold = 8'd1;
    do_dump(900, 0, "R6");
    track = 1'b0;
    do_dump(900, 0, "R6");
    track = 1'b1;
    hold = 8'd0;
    do_dump(0, 900, "R6");

    // full-scale inputs
    thr = 17'd65534;
    do_dump(32767, -32768, "R8");
    thr = 17'd65535;
    do_dump(32767, -32768, "R8");
    thr = 17'd0;
    do_dump(-32768, 32767, "R8");
    do_dump(7, 7, "R1");

    // reset clears a pending holdoff
    hold = 8'd5; thr = 17'd100;
    do_dump(900, 0, "R7");
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    hc = 0;
    @(negedge clk);
    chk(jump == 0 && step == 0, "R7", "outputs in mid reset", int'(jump), 0);
    rst_n = 1'b1;
    hold = 8'd0;
    do_dump(0, 900, "R7");
    do_dump(900, 0, "R4");

    repeat (3) @(negedge clk);
    done = 1;
    chk(sb.size() == 0, "R3", "pending results", sb.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule